// File: doc/BRIEF.md
# Redriver Link Power-State Controller

This block is the control state machine of a two-channel SuperSpeed USB signal redriver. It decides when the input and output terminations are on, when the transmitter floats or sends electrical idle, and when the main datapath (equalizer and output driver) is powered. The analog pieces are outside it. The far-end termination sensor is a request/done handshake with one found flag per channel. The signal-level comparators arrive as per-channel idle and LFPS activity flags.

The controller has five modes. In sleep everything is off. The detect mode probes the far end with the input termination released. The low-power retry mode sits with the circuitry gated off and re-probes on a long interval. Active mode passes data. The U2/U3 low-power mode is entered after a qualified stretch of idle on every channel. From U2/U3 it re-probes the far end with the terminations left on, and it returns to active mode on LFPS. An enable pin, passed through a synchronizer and a rising-edge detector, moves the block in and out of sleep. Dropping the enable and raising it again restarts detection. Every interval comes from a parameterized cycle count on one clock.

Top module: `rdrv_link_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied and just after it is released, `mode_o` is 0 (sleep). Both terminations are off, `tx_hiz_o` is 1, `pwr_main_o` is 0 and `det_req_o` is 0.
- R2: Starting in sleep, `en_i` rising moves `mode_o` to 1 (detect) within WAKE_CYC+3 cycles and no sooner than WAKE_CYC cycles. In detect, `det_req_o` is 1 and the input termination `rx_term_o` is 0.
- R3: A detect probe whose done strobe reports a receiver on every channel moves the block to mode 3 (active). In active mode both terminations are 1, `tx_hiz_o` is 0 and `pwr_main_o` is 1.
- R4: A detect probe in which any channel reports no receiver moves the block to mode 2 (low-power retry). There the terminations are off, `tx_hiz_o` is 1 and `pwr_main_o` is 0. Exactly RETRY_CYC cycles later the block probes again, and it repeats this until a probe succeeds.
- R5: When the synchronized enable is low, the block is in mode 0 no more than 3 cycles after `en_i` falls, from any mode. This includes coming out of reset with `en_i` low. In sleep, both terminations are off, the transmitter is high impedance and the main power is off.
- R6: Lowering `en_i` and then raising it again restarts the receiver-detect sequence from mode 1.
- R7: In active mode, U23_IDLE_CYC consecutive cycles with `idle_i` set on every channel move the block to mode 4 (U2/U3). A cycle with any channel not idle restarts the count. In U2/U3 both terminations stay on, `pwr_main_o` is 0 and every `tx_eidle_o` bit is 1.
- R8: In U2/U3, any bit of `lfps_i` moves the block to active mode on the next clock edge.
- R9: In U2/U3 a probe is raised every U23_PROBE_CYC cycles, and the mode stays 4 with `rx_term_o` held at 1. A successful probe returns the block to the U2/U3 wait. A failed probe moves it to mode 1 with `rx_term_o` at 0.
- R10: In active mode each `tx_eidle_o[i]` equals `idle_i[i]` of the previous cycle.
- R11: `mode_o` only takes the codes 0 to 4. `mode_chg_o` is 1 for exactly the cycles in which `mode_o` differs from its value in the previous cycle.
- R12: A `det_done_i` strobe while no probe is outstanding (`det_req_o` low) has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Asynchronous enable; low requests sleep |
| det_done_i | input | 1 | One-cycle strobe ending a far-end probe |
| det_found_i | input | NCH | Per-channel receiver-found flags, valid with the strobe |
| idle_i | input | NCH | Per-channel input electrical-idle flags |
| lfps_i | input | NCH | Per-channel LFPS activity flags |
| det_req_o | output | 1 | Probe request to the sensing circuit |
| rx_term_o | output | 1 | Input differential termination enable |
| tx_term_o | output | 1 | Output differential termination enable |
| tx_hiz_o | output | 1 | Transmitter high-impedance control |
| tx_eidle_o | output | NCH | Per-channel transmitter electrical-idle control |
| pwr_main_o | output | 1 | Power enable for equalizer and driver |
| mode_o | output | 3 | Mode code: 0 sleep, 1 detect, 2 retry, 3 active, 4 U2/U3 |
| mode_chg_o | output | 1 | One-cycle pulse on every mode change |

## Verification
Some properties are checked on every cycle:
- the output pattern each mode implies for terminations, power and transmitter state;
- the legal mode codes and the mode-change pulse;
- the one-cycle forwarding of idle in active mode;
- the reaction to a low enable and to LFPS.

Other behaviour only shows up in the bench's scenarios:
- the lengths of the retry, wake and idle-qualification windows;
- the count restarting when idle is broken;
- the two outcomes of a probe taken in U2/U3;
- the enable toggle restarting detection;
- a stray done strobe being ignored.

// File: rtl/rdrv_pkg.sv
`timescale 1ns/1ps
package rdrv_pkg;

  typedef enum logic [2:0] {
    MODE_SLEEP    = 3'd0,
    MODE_DETECT   = 3'd1,
    MODE_RXDET_LP = 3'd2,
    MODE_ACTIVE   = 3'd3,
    MODE_U23      = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_WAKE,
    ST_PROBE,
    ST_RETRY,
    ST_ACTIVE,
    ST_U23,
    ST_U23_PROBE
  } state_e;

  function automatic mode_e mode_of(input state_e s);
    case (s)
      ST_PROBE:              return MODE_DETECT;
      ST_RETRY:              return MODE_RXDET_LP;
      ST_ACTIVE:             return MODE_ACTIVE;
      ST_U23, ST_U23_PROBE:  return MODE_U23;
      default:               return MODE_SLEEP;
    endcase
  endfunction

endpackage

// File: rtl/rdrv_sync_edge.sv
`timescale 1ns/1ps
module rdrv_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rdrv_timer.sv
`timescale 1ns/1ps
module rdrv_timer #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rdrv_eidle_fwd.sv
`timescale 1ns/1ps
module rdrv_eidle_fwd #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           force_idle,
  input  logic [NCH-1:0] idle_in,
  output logic [NCH-1:0] eidle_out
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) eidle_out[i] <= 1'b1;
      else     eidle_out[i] <= force_idle | idle_in[i];
    end
  end
endmodule

// File: rtl/rdrv_link_ctrl.sv
`timescale 1ns/1ps
module rdrv_link_ctrl
  import rdrv_pkg::*;
#(
  parameter int NCH           = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int WAKE_CYC      = 2000,
  parameter int RETRY_CYC     = 2400000,
  parameter int U23_IDLE_CYC  = 20000,
  parameter int U23_PROBE_CYC = 2400000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic           det_done_i,
  input  logic [NCH-1:0] det_found_i,
  input  logic [NCH-1:0] idle_i,
  input  logic [NCH-1:0] lfps_i,
  output logic           det_req_o,
  output logic           rx_term_o,
  output logic           tx_term_o,
  output logic           tx_hiz_o,
  output logic [NCH-1:0] tx_eidle_o,
  output logic           pwr_main_o,
  output logic [2:0]     mode_o,
  output logic           mode_chg_o
);
  localparam int MAX_A = (WAKE_CYC > RETRY_CYC) ? WAKE_CYC : RETRY_CYC;
  localparam int MAX_B = (U23_IDLE_CYC > U23_PROBE_CYC) ? U23_IDLE_CYC : U23_PROBE_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAXC + 1);

  state_e         state, state_nx;
  logic           en_lvl, en_rise;
  logic           tmr_load, tmr_exp;
  logic [TW-1:0]  tmr_val;
  logic           all_idle;

  rdrv_sync_edge #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(clk), .rst(rst), .din(en_i), .lvl(en_lvl), .rise(en_rise)
  );

  assign all_idle = &idle_i;

  always_comb begin
    state_nx = state;
    case (state)
      ST_SLEEP:     if (en_rise) state_nx = ST_WAKE;
      ST_WAKE:      if (tmr_exp) state_nx = ST_PROBE;
      ST_PROBE:     if (det_done_i) state_nx = (&det_found_i) ? ST_ACTIVE : ST_RETRY;
      ST_RETRY:     if (tmr_exp) state_nx = ST_PROBE;
      ST_ACTIVE:    if (all_idle && tmr_exp) state_nx = ST_U23;
      ST_U23: begin
        if (|lfps_i)      state_nx = ST_ACTIVE;
        else if (tmr_exp) state_nx = ST_U23_PROBE;
      end
      ST_U23_PROBE: if (det_done_i) state_nx = (&det_found_i) ? ST_U23 : ST_PROBE;
      default:      state_nx = ST_SLEEP;
    endcase
    if (!en_lvl) state_nx = ST_SLEEP;
  end

  always_comb begin
    case (state_nx)
      ST_WAKE:   tmr_val = TW'(WAKE_CYC - 1);
      ST_RETRY:  tmr_val = TW'(RETRY_CYC - 1);
      ST_ACTIVE: tmr_val = TW'(U23_IDLE_CYC - 1);
      ST_U23:    tmr_val = TW'(U23_PROBE_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_nx != state) || (state == ST_ACTIVE && !all_idle);

  rdrv_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  rdrv_eidle_fwd #(.NCH(NCH)) u_eidle (
    .clk(clk), .rst(rst), .force_idle(state_nx != ST_ACTIVE),
    .idle_in(idle_i), .eidle_out(tx_eidle_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SLEEP;
      mode_o     <= MODE_SLEEP;
      mode_chg_o <= 1'b0;
      det_req_o  <= 1'b0;
      rx_term_o  <= 1'b0;
      tx_term_o  <= 1'b0;
      tx_hiz_o   <= 1'b1;
      pwr_main_o <= 1'b0;
    end else begin
      state      <= state_nx;
      mode_o     <= mode_of(state_nx);
      mode_chg_o <= (mode_of(state_nx) != mode_of(state));
      det_req_o  <= (state_nx == ST_PROBE) || (state_nx == ST_U23_PROBE);
      rx_term_o  <= state_nx inside {ST_ACTIVE, ST_U23, ST_U23_PROBE};
      tx_term_o  <= state_nx inside {ST_ACTIVE, ST_U23, ST_U23_PROBE};
      tx_hiz_o   <= !(state_nx inside {ST_ACTIVE, ST_U23, ST_U23_PROBE});
      pwr_main_o <= (state_nx == ST_ACTIVE);
    end
  end

  // Mode-implied output patterns
  assert_sleep_off_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_SLEEP) |-> (!rx_term_o && !tx_term_o && tx_hiz_o && !pwr_main_o && !det_req_o));
  assert_detect_rxoff_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_DETECT) |-> !rx_term_o);
  assert_active_on_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_ACTIVE) |-> (rx_term_o && tx_term_o && !tx_hiz_o && pwr_main_o));
  assert_retry_off_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_RXDET_LP) |-> (!rx_term_o && tx_hiz_o && !pwr_main_o && !det_req_o));
  assert_u23_lowpwr_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_U23) |-> (!pwr_main_o && rx_term_o && tx_term_o && (&tx_eidle_o)));
  assert_probe_mode_R9: assert property (@(posedge clk) disable iff (rst)
    det_req_o |-> (mode_o == MODE_DETECT || mode_o == MODE_U23));
  // Reactions
  assert_en_low_sleep_R5: assert property (@(posedge clk) disable iff (rst)
    !en_lvl |=> (mode_o == MODE_SLEEP));
  assert_lfps_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_U23 && (|lfps_i) && en_lvl) |=> (mode_o == MODE_ACTIVE));
  assert_idle_fwd_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_ACTIVE) |-> (tx_eidle_o == $past(idle_i)));
  // Mode code and change pulse
  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (rst)
    mode_o <= 3'd4);
  assert_chg_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    mode_chg_o |-> (mode_o != $past(mode_o)));
  assert_chg_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !mode_chg_o |-> $stable(mode_o));
endmodule

// File: tb/rdrv_link_ctrl_tb.sv
`timescale 1ns/1ps
module rdrv_link_ctrl_tb;
  localparam int NCH   = 2;
  localparam int WAKE  = 8;
  localparam int RETRY = 20;
  localparam int IDLE  = 10;
  localparam int PROBE = 30;

  localparam logic [2:0] M_SLEEP = 3'd0, M_DET = 3'd1, M_LP = 3'd2, M_ACT = 3'd3, M_U23 = 3'd4;

  // {idle[1:0], expected tx_eidle[1:0]} applied in active mode (R10)
  localparam logic [3:0] IDLE_VEC [8] = '{4'b00_00, 4'b01_01, 4'b10_10, 4'b00_00,
                                           4'b11_11, 4'b00_00, 4'b10_10, 4'b01_01};

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, det_done = 1'b0;
  logic [NCH-1:0] far_found = 2'b00, idle = 2'b00, lfps = 2'b00;
  logic det_req, rx_term, tx_term, tx_hiz, pwr_main, mode_chg;
  logic [NCH-1:0] tx_eidle;
  logic [2:0] mode;
  bit resp_on = 1'b0;
  int stray_req = 0, stray_ack = 0;
  int nchk = 0, nfail = 0, mism = 0, trans = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rdrv_link_ctrl #(.NCH(NCH), .WAKE_CYC(WAKE), .RETRY_CYC(RETRY),
                   .U23_IDLE_CYC(IDLE), .U23_PROBE_CYC(PROBE)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .det_done_i(det_done), .det_found_i(far_found),
    .idle_i(idle), .lfps_i(lfps), .det_req_o(det_req), .rx_term_o(rx_term),
    .tx_term_o(tx_term), .tx_hiz_o(tx_hiz), .tx_eidle_o(tx_eidle), .pwr_main_o(pwr_main),
    .mode_o(mode), .mode_chg_o(mode_chg)
  );

  // Far-end sensing model: answers a request on its third cycle, or sends a stray strobe
  initial begin
    int rcnt = 0;
    forever begin
      @(negedge clk);
      det_done = 1'b0;
      if (stray_req != stray_ack) begin
        det_done = 1'b1;
        stray_ack = stray_req;
      end else if (resp_on && det_req) begin
        rcnt++;
        if (rcnt == 3) begin
          det_done = 1'b1;
          rcnt = 0;
        end
      end else rcnt = 0;
    end
  end

  // Mode-change pulse monitor (R11)
  initial begin
    logic [2:0] pm = M_SLEEP;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if ((mode != pm) != mode_chg) mism++;
        if (mode != pm) trans++;
        pm = mode;
      end
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input string what, input int act, input int lo, input int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mode(input logic [2:0] m, input int maxc, output int n);
    n = 0;
    while (mode != m && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset state
    tick(3);
    check_eq("R1", "mode in reset", int'(mode), int'(M_SLEEP));
    rst = 1'b0;
    tick(1);
    check_eq("R1", "mode after reset", int'(mode), int'(M_SLEEP));
    check_eq("R1", "rx_term", int'(rx_term), 0);
    check_eq("R1", "tx_term", int'(tx_term), 0);
    check_eq("R1", "tx_hiz", int'(tx_hiz), 1);
    check_eq("R1", "pwr_main", int'(pwr_main), 0);
    check_eq("R1", "det_req", int'(det_req), 0);
    // R5: power-up with enable low stays asleep
    tick(20);
    check_eq("R5", "mode with en low at power-up", int'(mode), int'(M_SLEEP));

    // R2: enable rise leads to detect
    far_found = 2'b01;
    resp_on = 1'b1;
    en = 1'b1;
    wait_mode(M_DET, 200, n);
    check_eq("R2", "reached detect", int'(mode), int'(M_DET));
    check_rng("R2", "wake latency", n, WAKE, WAKE + 3);
    check_eq("R2", "rx_term in detect", int'(rx_term), 0);
    check_eq("R2", "det_req in detect", int'(det_req), 1);

    // R4: failed probe goes to low-power retry, retried after RETRY cycles
    wait_mode(M_LP, 50, n);
    check_eq("R4", "retry mode after fail", int'(mode), int'(M_LP));
    check_eq("R4", "tx_hiz in retry", int'(tx_hiz), 1);
    check_eq("R4", "pwr_main in retry", int'(pwr_main), 0);
    check_eq("R4", "tx_term in retry", int'(tx_term), 0);
    wait_mode(M_DET, 200, n);
    check_eq("R4", "retry interval", n, RETRY);
    wait_mode(M_LP, 50, n);
    check_eq("R4", "second retry", int'(mode), int'(M_LP));

    // R3: both channels found -> active
    far_found = 2'b11;
    wait_mode(M_ACT, 200, n);
    check_eq("R3", "active reached", int'(mode), int'(M_ACT));
    check_eq("R3", "rx_term", int'(rx_term), 1);
    check_eq("R3", "tx_term", int'(tx_term), 1);
    check_eq("R3", "tx_hiz", int'(tx_hiz), 0);
    check_eq("R3", "pwr_main", int'(pwr_main), 1);

    // R10: idle forwarding table
    foreach (IDLE_VEC[k]) begin
      idle = IDLE_VEC[k][3:2];
      tick(1);
      check_eq("R10", $sformatf("tx_eidle vec %0d", k), int'(tx_eidle), int'(IDLE_VEC[k][1:0]));
      check_eq("R10", $sformatf("mode vec %0d", k), int'(mode), int'(M_ACT));
    end
    idle = 2'b00;
    tick(1);

    // R12: stray done strobe with a failing result is ignored in active mode
    far_found = 2'b00;
    stray_req++;
    tick(4);
    check_eq("R12", "mode after stray done", int'(mode), int'(M_ACT));
    far_found = 2'b11;

    // R7: broken idle restarts the count, then full window enters U2/U3
    idle = 2'b11;
    tick(IDLE - 2);
    idle = 2'b01;
    tick(1);
    check_eq("R7", "still active after broken idle", int'(mode), int'(M_ACT));
    idle = 2'b11;
    wait_mode(M_U23, 100, n);
    check_eq("R7", "idle window", n, IDLE);
    check_eq("R7", "pwr_main in U23", int'(pwr_main), 0);
    check_eq("R7", "rx_term in U23", int'(rx_term), 1);
    check_eq("R7", "tx_term in U23", int'(tx_term), 1);
    check_eq("R7", "tx_eidle in U23", int'(tx_eidle), 3);

    // R8: LFPS wakes to active
    tick(2);
    lfps = 2'b10;
    tick(1);
    check_eq("R8", "active after LFPS", int'(mode), int'(M_ACT));
    lfps = 2'b00;
    wait_mode(M_U23, 100, n);
    check_eq("R7", "U23 re-entered", int'(mode), int'(M_U23));

    // R9: periodic probe in U2/U3, success keeps U2/U3
    n = 0;
    while (!det_req && n < PROBE + 10) begin
      tick(1);
      n++;
    end
    check_rng("R9", "probe interval", n, PROBE - 1, PROBE + 1);
    check_eq("R9", "mode during U23 probe", int'(mode), int'(M_U23));
    check_eq("R9", "rx_term during U23 probe", int'(rx_term), 1);
    tick(5);
    check_eq("R9", "mode after good probe", int'(mode), int'(M_U23));
    check_eq("R9", "det_req after good probe", int'(det_req), 0);
    // R9: failed probe falls back to power-up detect
    far_found = 2'b10;
    wait_mode(M_DET, PROBE + 20, n);
    check_eq("R9", "detect after failed U23 probe", int'(mode), int'(M_DET));
    check_eq("R9", "rx_term after failed probe", int'(rx_term), 0);
    idle = 2'b00;
    far_found = 2'b11;
    wait_mode(M_ACT, 200, n);
    check_eq("R3", "active after recovery", int'(mode), int'(M_ACT));

    // R5: enable low from active
    en = 1'b0;
    wait_mode(M_SLEEP, 20, n);
    check_eq("R5", "sleep reached", int'(mode), int'(M_SLEEP));
    check_rng("R5", "sleep latency", n, 1, 3);
    check_eq("R5", "rx_term in sleep", int'(rx_term), 0);
    check_eq("R5", "tx_hiz in sleep", int'(tx_hiz), 1);

    // R6: re-enable restarts detection
    tick(3);
    en = 1'b1;
    wait_mode(M_DET, 200, n);
    check_eq("R6", "detect after toggle", int'(mode), int'(M_DET));
    wait_mode(M_ACT, 50, n);
    check_eq("R6", "active after toggle", int'(mode), int'(M_ACT));

    // R11: change pulse consistency over the whole run
    check_eq("R11", "mode_chg mismatches", mism, 0);
    check_rng("R11", "mode transitions seen", trans, 10, 1000);
    check_rng("R11", "mode code legal", int'(mode), 0, 4);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule